// File: doc/BRIEF.md
# Calendar Real-Time Clock with Timed Update Sequence

This block keeps wall-clock time (seconds, minutes, hours, weekday, day of month, month and two-digit year) together with a seconds/minutes/hours alarm and a general-purpose byte store. All of it sits in one 256-byte index space. A host reaches that space through two index/data port pairs. The low pair addresses indices 00h–7Fh. The high pair addresses 80h–FFh.

A one-cycle pulse on `sec_tick` starts an update. The block first raises an update-busy flag, then waits a fixed lead time. It then advances the calendar with the full carry chain, compares the new time against the alarm, and finally latches an update-finished flag and drops the busy flag. Time values read while the busy flag is high are not guaranteed. Two flags (alarm hit and update finished) can each drive the interrupt output, gated by an enable bit.

Top module: `rtc_calendar`

## Requirements
- R1: After reset: seconds, minutes, hours and year read 0; weekday, day of month and month read 1; the flag register (index 0Ch) reads 00h.
- R2: Each accepted `sec_tick` advances the seconds byte (index 00h) by exactly one, wrapping 59 to 0.
- R3: Seconds wrap carries into minutes (02h, wraps 59→0). Minutes carry into hours (04h, wraps 23→0). Hours carry into weekday (06h, 7→1) and day of month (07h). Day of month carries into month (08h, 12→1), and month carries into year (09h, 99→0).
- R4: Day of month wraps to 1 past 30 for months 4, 6, 9 and 11, past 31 for other months, and past 28 in February unless year mod 4 is 0, when it wraps past 29.
- R5: Bit 7 of index 0Ah reads 1 from the cycle after an accepted tick until the update completes, and reads 0 otherwise. The lead time before the counters change is `LEAD_CYCLES` clocks.
- R6: Host writes to indices 00h–09h are dropped while bit 7 of 0Ah is 1.
- R7: With bit 7 of index 0Bh set, ticks are ignored and the time does not change.
- R8: When the post-update seconds, minutes and hours equal the alarm bytes (01h, 03h, 05h), bit 5 of index 0Ch is set.
- R9: Each completed update sets bit 4 of index 0Ch. A read of index 0Ch returns the flags and clears bits 5 and 4.
- R10: `irq` equals (bit 5 of 0Ch AND bit 5 of 0Bh) OR (bit 4 of 0Ch AND bit 4 of 0Bh). Bit 7 of 0Ch reads back the value of `irq`.
- R11: Indices 0Eh–7Fh, reached through bus address 0 (index) and 1 (data), store and return any byte.
- R12: Bus addresses 2 (index) and 3 (data) reach indices 80h–FFh (index byte bits 6:0 plus 80h). These bytes are separate from the low indices that share the same low seven bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| bus_addr | input | 2 | 0/1: low index/data, 2/3: high index/data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` the next cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that the host only ever loads in-range calendar values: seconds and minutes below 60, hours below 24, weekday 1–7, a day of month valid for the month, and a month of 1–12. Under that assumption the single-step seconds check and the day-of-month range check hold. The bench keeps to this by writing only legal dates before each tick. It also spaces ticks further apart than a full update, so no tick lands while an update is running.

// File: rtl/rtc_pkg.sv
// Shared types, index constants and calendar helpers for the real-time clock.
// Assumes binary (not BCD) encoding of all time fields.
package rtc_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LEAD,
        SQ_ADV,
        SQ_CMP,
        SQ_FIN
    } seq_state_t;

    localparam logic [7:0] IX_SEC   = 8'h00;
    localparam logic [7:0] IX_ASEC  = 8'h01;
    localparam logic [7:0] IX_MIN   = 8'h02;
    localparam logic [7:0] IX_AMIN  = 8'h03;
    localparam logic [7:0] IX_HR    = 8'h04;
    localparam logic [7:0] IX_AHR   = 8'h05;
    localparam logic [7:0] IX_DOW   = 8'h06;
    localparam logic [7:0] IX_DATE  = 8'h07;
    localparam logic [7:0] IX_MON   = 8'h08;
    localparam logic [7:0] IX_YEAR  = 8'h09;
    localparam logic [7:0] IX_CFGA  = 8'h0A;
    localparam logic [7:0] IX_CFGB  = 8'h0B;
    localparam logic [7:0] IX_FLAGS = 8'h0C;
    localparam logic [7:0] IX_STAT  = 8'h0D;
    localparam logic [7:0] IX_RAM0  = 8'h0E;

    // Number of days in a month; leap February when the year is a multiple of 4.
    function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] year);
        case (mon)
            8'd2:                    return (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
            default:                 return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_advance.sv
// Combinational next-second calculator: applies one second and the full carry
// chain through minutes, hours, weekday, day of month, month and year.
// Assumes the current value is in range.
module rtc_advance
    import rtc_pkg::*;
#(
    parameter int SEC_MAX  = 59,
    parameter int MIN_MAX  = 59,
    parameter int HR_MAX   = 23,
    parameter int DOW_MAX  = 7,
    parameter int MON_MAX  = 12,
    parameter int YEAR_MAX = 99
) (
    input  rtc_time_t cur,
    output rtc_time_t nxt
);

    localparam logic [7:0] SEC_TOP  = 8'(SEC_MAX);
    localparam logic [7:0] MIN_TOP  = 8'(MIN_MAX);
    localparam logic [7:0] HR_TOP   = 8'(HR_MAX);
    localparam logic [7:0] DOW_TOP  = 8'(DOW_MAX);
    localparam logic [7:0] MON_TOP  = 8'(MON_MAX);
    localparam logic [7:0] YEAR_TOP = 8'(YEAR_MAX);

    logic [7:0] dim;

    // Month length for the current month and year.
    always_comb dim = month_days(cur.mon, cur.year);

    // Ripple the carry from seconds up to the year.
    always_comb begin
        nxt = cur;
        if (cur.sec >= SEC_TOP) begin
            nxt.sec = 8'd0;
            if (cur.min >= MIN_TOP) begin
                nxt.min = 8'd0;
                if (cur.hr >= HR_TOP) begin
                    nxt.hr  = 8'd0;
                    nxt.dow = (cur.dow >= DOW_TOP) ? 8'd1 : cur.dow + 8'd1;
                    if (cur.date >= dim) begin
                        nxt.date = 8'd1;
                        if (cur.mon >= MON_TOP) begin
                            nxt.mon  = 8'd1;
                            nxt.year = (cur.year >= YEAR_TOP) ? 8'd0 : cur.year + 8'd1;
                        end else begin
                            nxt.mon = cur.mon + 8'd1;
                        end
                    end else begin
                        nxt.date = cur.date + 8'd1;
                    end
                end else begin
                    nxt.hr = cur.hr + 8'd1;
                end
            end else begin
                nxt.min = cur.min + 8'd1;
            end
        end else begin
            nxt.sec = cur.sec + 8'd1;
        end
    end

endmodule

// File: rtl/rtc_update_seq.sv
// Update sequencer: on an accepted tick raises busy, waits LEAD_CYCLES, then
// strobes advance, compare and finish in three consecutive cycles.
// Assumes ticks are single-cycle; ticks during an update or while halted are dropped.
module rtc_update_seq
    import rtc_pkg::*;
#(
    parameter int LEAD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic halt,
    output logic busy,
    output logic adv,
    output logic cmp,
    output logic fin
);

    localparam int CW = $clog2(LEAD_CYCLES + 1);
    localparam logic [CW-1:0] LEAD_LAST = CW'(LEAD_CYCLES - 1);

    seq_state_t      state;
    logic [CW-1:0]   cnt;

    // State register and lead-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (tick && !halt) begin
                    state <= SQ_LEAD;
                    cnt   <= '0;
                end
                SQ_LEAD: if (cnt == LEAD_LAST) state <= SQ_ADV;
                         else cnt <= cnt + 1'b1;
                SQ_ADV:  state <= SQ_CMP;
                SQ_CMP:  state <= SQ_FIN;
                SQ_FIN:  state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Decode phase strobes from the state.
    always_comb begin
        busy = (state != SQ_IDLE);
        adv  = (state == SQ_ADV);
        cmp  = (state == SQ_CMP);
        fin  = (state == SQ_FIN);
    end

    // An accepted tick raises busy on the next cycle.
    assert_busy_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && tick && !halt) |=> busy);

    // A halted, idle sequencer stays idle.
    assert_halt_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && halt) |=> !busy);

    // Advance only ever follows the lead phase.
    assert_adv_after_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> $past(busy));

endmodule

// File: rtl/rtc_user_ram.sv
// General-purpose byte store for the user area of the index space.
// Asynchronous read, synchronous write; locations below the user area go unused.
module rtc_user_ram #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // Store a byte on a write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Return the addressed byte.
    always_comb rdata = mem[raddr];

endmodule

// File: rtl/rtc_calendar.sv
// Real-time clock top: calendar and alarm registers, control and flag
// registers, user store, and two index/data port pairs over a 256-byte space.
// Assumes the host writes only in-range time values.
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int LEAD_CYCLES = 4,
    parameter int YEAR_MAX    = 99
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);

    localparam int IXW = 7;

    rtc_time_t      tm, tm_next;
    logic [7:0]     al_sec, al_min, al_hr;
    logic [6:0]     cfg_a;
    logic [7:0]     cfg_b;
    logic           alarm_flag, done_flag;
    logic [IXW-1:0] ix_lo, ix_hi;
    logic [7:0]     eff_ix;
    logic           busy, adv, cmp, fin;
    logic           data_wr, data_rd, flags_rd, time_wr;
    logic [7:0]     ram_rdata, rd_val;
    logic           alarm_hit;

    rtc_update_seq #(.LEAD_CYCLES(LEAD_CYCLES)) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (sec_tick),
        .halt (cfg_b[7]),
        .busy (busy),
        .adv  (adv),
        .cmp  (cmp),
        .fin  (fin)
    );

    rtc_advance #(.YEAR_MAX(YEAR_MAX)) u_adv (
        .cur(tm),
        .nxt(tm_next)
    );

    rtc_user_ram #(.AW(8)) u_ram (
        .clk  (clk),
        .we   (data_wr && (eff_ix >= IX_RAM0)),
        .waddr(eff_ix),
        .wdata(bus_wdata),
        .raddr(eff_ix),
        .rdata(ram_rdata)
    );

    // Decode the effective index and the data-port strobes.
    always_comb begin
        eff_ix    = bus_addr[1] ? {1'b1, ix_hi} : {1'b0, ix_lo};
        data_wr   = bus_wr && bus_addr[0];
        data_rd   = bus_rd && bus_addr[0];
        flags_rd  = data_rd && (eff_ix == IX_FLAGS);
        time_wr   = data_wr && !busy && (eff_ix <= IX_YEAR);
        alarm_hit = (tm.sec == al_sec) && (tm.min == al_min) && (tm.hr == al_hr);
        irq       = (alarm_flag && cfg_b[5]) || (done_flag && cfg_b[4]);
    end

    // Index registers of both port pairs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ix_lo <= '0;
            ix_hi <= '0;
        end else if (bus_wr && !bus_addr[0]) begin
            if (bus_addr[1]) ix_hi <= bus_wdata[IXW-1:0];
            else             ix_lo <= bus_wdata[IXW-1:0];
        end
    end

    // Calendar and alarm registers: update advance, else host writes when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tm      <= '{year: 8'd0, mon: 8'd1, date: 8'd1, dow: 8'd1,
                         hr: 8'd0, min: 8'd0, sec: 8'd0};
            al_sec  <= '0;
            al_min  <= '0;
            al_hr   <= '0;
        end else if (adv) begin
            tm <= tm_next;
        end else if (time_wr) begin
            case (eff_ix)
                IX_SEC:  tm.sec  <= bus_wdata;
                IX_ASEC: al_sec  <= bus_wdata;
                IX_MIN:  tm.min  <= bus_wdata;
                IX_AMIN: al_min  <= bus_wdata;
                IX_HR:   tm.hr   <= bus_wdata;
                IX_AHR:  al_hr   <= bus_wdata;
                IX_DOW:  tm.dow  <= bus_wdata;
                IX_DATE: tm.date <= bus_wdata;
                IX_MON:  tm.mon  <= bus_wdata;
                default: tm.year <= bus_wdata;
            endcase
        end
    end

    // Control registers A (low seven bits) and B.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_a <= '0;
            cfg_b <= '0;
        end else if (data_wr) begin
            if (eff_ix == IX_CFGA) cfg_a <= bus_wdata[6:0];
            if (eff_ix == IX_CFGB) cfg_b <= bus_wdata;
        end
    end

    // Event flags: cleared by a flag-register read, set by the update (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_flag <= 1'b0;
            done_flag  <= 1'b0;
        end else begin
            if (flags_rd) begin
                alarm_flag <= 1'b0;
                done_flag  <= 1'b0;
            end
            if (cmp && alarm_hit) alarm_flag <= 1'b1;
            if (fin)              done_flag  <= 1'b1;
        end
    end

    // Read multiplexer over the index space.
    always_comb begin
        case (eff_ix)
            IX_SEC:   rd_val = tm.sec;
            IX_ASEC:  rd_val = al_sec;
            IX_MIN:   rd_val = tm.min;
            IX_AMIN:  rd_val = al_min;
            IX_HR:    rd_val = tm.hr;
            IX_AHR:   rd_val = al_hr;
            IX_DOW:   rd_val = tm.dow;
            IX_DATE:  rd_val = tm.date;
            IX_MON:   rd_val = tm.mon;
            IX_YEAR:  rd_val = tm.year;
            IX_CFGA:  rd_val = {busy, cfg_a};
            IX_CFGB:  rd_val = cfg_b;
            IX_FLAGS: rd_val = {irq, 1'b0, alarm_flag, done_flag, 4'b0000};
            IX_STAT:  rd_val = 8'h80;
            default:  rd_val = ram_rdata;
        endcase
    end

    // Registered read data for index and data ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= bus_addr[0] ? rd_val : eff_ix;
        end
    end

    // Seconds step by one (or wrap) on each advance.
    assert_sec_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (tm.sec == 8'($past(tm.sec) + 8'd1)) || (tm.sec == 8'd0 && $past(tm.sec) == 8'd59));

    // Day of month stays within 1..31 for in-range host values.
    assert_date_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tm.date >= 8'd1) && (tm.date <= 8'd31));

    // Finish of an update leaves the done flag set.
    assert_done_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> done_flag);

    // Time registers hold still while busy, except for the advance.
    assert_no_write_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !adv) |=> $stable(tm.sec));

endmodule

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_prev = 1'b0;

    always #5 clk = ~clk;

    rtc_calendar u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic summary_and_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr_port(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_index(input logic [7:0] ix);
        wr_port(ix[7] ? 2'd2 : 2'd0, {1'b0, ix[6:0]});
    endtask

    task automatic wr_reg(input logic [7:0] ix, input logic [7:0] d);
        set_index(ix);
        wr_port(ix[7] ? 2'd3 : 2'd1, d);
    endtask

    // Driver: issues a read and pushes the expected byte to the scoreboard.
    task automatic rd_reg(input logic [7:0] ix, input logic [7:0] exp, input string tag);
        set_index(ix);
        @(negedge clk);
        bus_addr = ix[7] ? 2'd3 : 2'd1; bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_tick(input int gap);
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                            input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s);
        wr_reg(8'h09, y); wr_reg(8'h08, mo); wr_reg(8'h07, d);
        wr_reg(8'h04, h); wr_reg(8'h02, mi); wr_reg(8'h00, s);
    endtask

    // Monitor: pops the scoreboard as read data comes out.
    always @(posedge clk) rd_prev <= bus_rd;
    always @(negedge clk) begin
        if (rd_prev) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: unexpected read data %02h", bus_rdata);
            end else begin
                check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not end");
        summary_and_end();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(8'h00, 8'd0, "R1 sec");
        rd_reg(8'h06, 8'd1, "R1 dow");
        rd_reg(8'h07, 8'd1, "R1 date");
        rd_reg(8'h08, 8'd1, "R1 mon");
        rd_reg(8'h0C, 8'h00, "R1 flags");
        wr_reg(8'h05, 8'd30);   // alarm hour that never matches

        // R2 seconds step
        pulse_tick(15);
        rd_reg(8'h00, 8'd1, "R2 sec after tick 1");
        pulse_tick(15);
        rd_reg(8'h00, 8'd2, "R2 sec after tick 2");

        // R3 full carry chain
        set_time(8'd99, 8'd12, 8'd31, 8'd23, 8'd59, 8'd59);
        wr_reg(8'h06, 8'd7);
        pulse_tick(15);
        rd_reg(8'h00, 8'd0, "R3 sec");
        rd_reg(8'h02, 8'd0, "R3 min");
        rd_reg(8'h04, 8'd0, "R3 hr");
        rd_reg(8'h06, 8'd1, "R3 dow");
        rd_reg(8'h07, 8'd1, "R3 date");
        rd_reg(8'h08, 8'd1, "R3 mon");
        rd_reg(8'h09, 8'd0, "R3 year");

        // R4 month lengths and leap years
        set_time(8'd4, 8'd2, 8'd28, 8'd23, 8'd59, 8'd59);
        pulse_tick(15);
        rd_reg(8'h07, 8'd29, "R4 leap feb 28->29");
        set_time(8'd4, 8'd2, 8'd29, 8'd23, 8'd59, 8'd59);
        pulse_tick(15);
        rd_reg(8'h07, 8'd1, "R4 leap feb 29 date");
        rd_reg(8'h08, 8'd3, "R4 leap feb 29 mon");
        set_time(8'd3, 8'd2, 8'd28, 8'd23, 8'd59, 8'd59);
        pulse_tick(15);
        rd_reg(8'h08, 8'd3, "R4 non-leap feb mon");
        set_time(8'd3, 8'd4, 8'd30, 8'd23, 8'd59, 8'd59);
        pulse_tick(15);
        rd_reg(8'h07, 8'd1, "R4 april date");
        rd_reg(8'h08, 8'd5, "R4 april mon");

        // R5 update-busy bit around an update
        wr_reg(8'h00, 8'd10);
        pulse_tick(0);
        rd_reg(8'h0A, 8'h80, "R5 busy during update");
        repeat (15) @(negedge clk);
        rd_reg(8'h0A, 8'h00, "R5 idle after update");

        // R6 time write dropped during update
        pulse_tick(0);
        wr_reg(8'h00, 8'd40);
        repeat (15) @(negedge clk);
        rd_reg(8'h00, 8'd12, "R6 write during busy dropped");

        // R7 halt
        wr_reg(8'h0B, 8'h80);
        pulse_tick(15);
        rd_reg(8'h00, 8'd12, "R7 halted sec");
        wr_reg(8'h0B, 8'h00);

        // R9 pending done flag, then R8 alarm
        rd_reg(8'h0C, 8'h10, "R9 done flag pending");
        set_time(8'd5, 8'd6, 8'd7, 8'd10, 8'd20, 8'd29);
        wr_reg(8'h01, 8'd30); wr_reg(8'h03, 8'd20); wr_reg(8'h05, 8'd10);
        pulse_tick(15);
        rd_reg(8'h0C, 8'h30, "R8 alarm and done flags");
        rd_reg(8'h0C, 8'h00, "R9 flags cleared by read");

        // R10 interrupt gating
        pulse_tick(15);
        @(negedge clk);
        check({7'd0, irq}, 8'd0, "R10 irq masked");
        wr_reg(8'h0B, 8'h10);
        @(negedge clk);
        check({7'd0, irq}, 8'd1, "R10 irq on done enable");
        rd_reg(8'h0C, 8'h90, "R10 flag reg irq bit");
        @(negedge clk);
        check({7'd0, irq}, 8'd0, "R10 irq dropped after read");
        wr_reg(8'h0B, 8'h00);

        // R11 low user store
        wr_reg(8'h0E, 8'hA5);
        wr_reg(8'h7F, 8'h3C);
        rd_reg(8'h0E, 8'hA5, "R11 ram 0E");
        rd_reg(8'h7F, 8'h3C, "R11 ram 7F");

        // R12 high user store
        wr_reg(8'h85, 8'h5A);
        wr_reg(8'hFF, 8'hC3);
        rd_reg(8'h85, 8'h5A, "R12 ram 85");
        rd_reg(8'hFF, 8'hC3, "R12 ram FF");
        rd_reg(8'h05, 8'd10, "R12 low 05 untouched");
        rd_reg(8'h7F, 8'h3C, "R12 low 7F untouched");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: %0d reads never returned", exp_q.size());
        end
        summary_and_end();
    end

endmodule